// File: doc/BRIEF.md
# Two-Phase Serial Configuration Chain

This block loads the operating parameters of a digital voltage-regulation loop through four pins. An external host moves one bit into a 64-bit chain for each pass of two non-overlapping shift phases: a first phase (`shift_ph1`) and then a second phase (`shift_ph2`). When the whole word is in place, a pulse on `cfg_load` copies it into shadow registers in the system clock domain. The loop controller reads only those shadow registers, so it never sees a coefficient that is partly shifted.

The chain holds three 16-bit loop gains (proportional, integral, derivative), eight controller mode bits and eight oscillator trim bits. The system clock samples all four host pins through a two-stage synchronizer. A four-state phase tracker turns the sampled phase levels into load enables for a master stage and a slave stage:

- `PH_IDLE`: both phases are low.
- `PH_LOAD_M`: only the first phase is high. The master stage takes the slave contents shifted by one, with `cfg_sdi` in the lowest bit.
- `PH_LOAD_S`: only the second phase is high. The slave stage copies the master stage.
- `PH_CLASH`: both phases are high at once.

The tracker's transitions are as follows:

- From `PH_IDLE`, `PH_LOAD_M` or `PH_LOAD_S`, the next state follows the sampled levels: both high goes to `PH_CLASH`, first phase only goes to `PH_LOAD_M`, second phase only goes to `PH_LOAD_S`, and neither goes to `PH_IDLE`.
- `PH_CLASH` returns to `PH_IDLE` only when both phases are low. Otherwise it stays in `PH_CLASH`.

A rising edge of the sampled `cfg_load` is accepted only in `PH_IDLE`. The serial output is the top bit of the slave stage. Shifting a new word therefore brings the previous contents out, most significant bit first.

Top module: `scan_cfg_chain`

## Requirements
- R1: While `rst_n` is low, all shadow outputs and `cfg_sdo` are 0: all gains zero, all mode bits off, trim zero. An asynchronous reset in mid-run clears them at once.
- R2: One bit moves for each first-phase pulse followed by a second-phase pulse. The bit on `cfg_sdi` during the first phase enters the chain at bit 0, and the chain moves toward bit 63.
- R3: After 64 pairs and an accepted load, the outputs take these chain bits: `gain_p` = bits 63:48, `gain_i` = bits 47:32, `gain_d` = bits 31:16, `ctrl_bits` = bits 15:8, `osc_trim` = bits 7:0. The first bit shifted therefore becomes bit 15 of `gain_p`.
- R4: `cfg_sdo` always shows chain bit 63. While a new word is shifted, the old word comes out most significant bit first, one bit per pair.
- R5: The shadow outputs change only on an accepted load. They hold their values through any amount of shifting.
- R6: A rising edge of `cfg_load` that is sampled while a shift phase is active is ignored: the shadow outputs keep their values.
- R7: When both phases are sampled high together, the tracker enters `PH_CLASH`. The slave stage does not change until both phases are low, so that pair moves no bit.
- R8: Pin timing, counted in system clock edges after a pin change: the shadow outputs change on the 3rd edge after `cfg_load` rises, and `cfg_sdo` changes on the 4th edge after `shift_ph2` rises.
- R9: A second-phase pulse with no first-phase pulse before it, or a first-phase pulse with no second-phase pulse after it, leaves `cfg_sdo` and the chain contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_ph1 | input | 1 | First shift phase (master stage) |
| shift_ph2 | input | 1 | Second shift phase (slave stage), must not overlap `shift_ph1` |
| cfg_sdi | input | 1 | Serial data in |
| cfg_load | input | 1 | Load strobe; its rising edge copies the chain into the shadow registers |
| cfg_sdo | output | 1 | Serial data out, chain bit 63 |
| gain_p | output | 16 | Proportional gain |
| gain_i | output | 16 | Integral gain |
| gain_d | output | 16 | Derivative gain |
| ctrl_bits | output | 8 | Controller mode bits |
| osc_trim | output | 8 | Oscillator trim |

## Verification
A wrong phase-tracker state or a stray enable shows at `cfg_sdo` within four clocks of the second phase, as a bit that repeats, is skipped or comes too early. A master stage that is loaded wrongly stays hidden until the next second phase copies it out. A corrupted chain is not visible on the gain outputs until the next accepted load, and then appears as a shifted or wrong field. An update that is taken while a phase is active, or that is lost, shows on the shadow outputs exactly three clocks after `cfg_load` rises. For these reasons the reference model is compared with `cfg_sdo` and all five fields on every clock, not only at the end of a load.

// File: rtl/scan_cfg_pkg.sv
package scan_cfg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOAD_M = 2'd1,
        PH_LOAD_S = 2'd2,
        PH_CLASH  = 2'd3
    } ph_state_t;

    // Next state for the non-clash states, from the sampled phase levels
    function automatic ph_state_t follow_phases(input logic p1, input logic p2);
        if (p1 && p2)
            return PH_CLASH;
        else if (p1)
            return PH_LOAD_M;
        else if (p2)
            return PH_LOAD_S;
        else
            return PH_IDLE;
    endfunction

endpackage

// File: rtl/scan_pin_sync.sv
module scan_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_s
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++)
                pipe[i] <= '0;
        end else begin
            pipe[0] <= pin_i;
            for (int i = 1; i < STAGES; i++)
                pipe[i] <= pipe[i-1];
        end
    end

    assign pin_s = pipe[STAGES-1];

endmodule

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
    import scan_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ph1_s,
    input  logic      ph2_s,
    input  logic      load_s,
    output ph_state_t state,
    output logic      master_en,
    output logic      slave_en,
    output logic      shadow_en
);

    ph_state_t state_nx;
    logic      load_d;
    logic      load_rise;

    always_comb begin
        unique case (state)
            PH_IDLE,
            PH_LOAD_M,
            PH_LOAD_S: state_nx = follow_phases(ph1_s, ph2_s);
            PH_CLASH:  state_nx = (!ph1_s && !ph2_s) ? PH_IDLE : PH_CLASH;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PH_IDLE;
            load_d <= 1'b0;
        end else begin
            state  <= state_nx;
            load_d <= load_s;
        end
    end

    assign load_rise = load_s && !load_d;

    // Outputs
    always_comb begin
        master_en = 1'b0;
        slave_en  = 1'b0;
        shadow_en = 1'b0;
        unique case (state)
            PH_IDLE:   shadow_en = load_rise;
            PH_LOAD_M: master_en = 1'b1;
            PH_LOAD_S: slave_en  = 1'b1;
            PH_CLASH:  ;
        endcase
    end

endmodule

// File: rtl/scan_shift_cells.sv
module scan_shift_cells #(
    parameter int CHAIN_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master_en,
    input  logic               slave_en,
    input  logic               sdi_s,
    output logic [CHAIN_W-1:0] master_q,
    output logic [CHAIN_W-1:0] slave_q,
    output logic               sdo
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= '0;
            slave_q  <= '0;
        end else begin
            if (master_en)
                master_q <= {slave_q[CHAIN_W-2:0], sdi_s};
            if (slave_en)
                slave_q <= master_q;
        end
    end

    assign sdo = slave_q[CHAIN_W-1];

endmodule

// File: rtl/scan_shadow_regs.sv
module scan_shadow_regs #(
    parameter int COEF_W = 16,
    parameter int CTRL_W = 8,
    parameter int TRIM_W = 8,
    localparam int CHAIN_W = 3*COEF_W + CTRL_W + TRIM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [CHAIN_W-1:0] chain_q,
    output logic [COEF_W-1:0]  gain_p,
    output logic [COEF_W-1:0]  gain_i,
    output logic [COEF_W-1:0]  gain_d,
    output logic [CTRL_W-1:0]  ctrl_bits,
    output logic [TRIM_W-1:0]  osc_trim
);

    localparam int TRIM_LO = 0;
    localparam int CTRL_LO = TRIM_LO + TRIM_W;
    localparam int KD_LO   = CTRL_LO + CTRL_W;
    localparam int KI_LO   = KD_LO + COEF_W;
    localparam int KP_LO   = KI_LO + COEF_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_p    <= '0;
            gain_i    <= '0;
            gain_d    <= '0;
            ctrl_bits <= '0;
            osc_trim  <= '0;
        end else if (load_en) begin
            gain_p    <= chain_q[KP_LO   +: COEF_W];
            gain_i    <= chain_q[KI_LO   +: COEF_W];
            gain_d    <= chain_q[KD_LO   +: COEF_W];
            ctrl_bits <= chain_q[CTRL_LO +: CTRL_W];
            osc_trim  <= chain_q[TRIM_LO +: TRIM_W];
        end
    end

endmodule

// File: rtl/scan_cfg_chain.sv
module scan_cfg_chain
    import scan_cfg_pkg::*;
#(
    parameter int COEF_W      = 16,
    parameter int CTRL_W      = 8,
    parameter int TRIM_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_ph1,
    input  logic              shift_ph2,
    input  logic              cfg_sdi,
    input  logic              cfg_load,
    output logic              cfg_sdo,
    output logic [COEF_W-1:0] gain_p,
    output logic [COEF_W-1:0] gain_i,
    output logic [COEF_W-1:0] gain_d,
    output logic [CTRL_W-1:0] ctrl_bits,
    output logic [TRIM_W-1:0] osc_trim
);

    localparam int CHAIN_W = 3*COEF_W + CTRL_W + TRIM_W;

    logic [3:0]         pins_s;
    logic               ph1_s, ph2_s, sdi_s, load_s;
    ph_state_t          ph_state;
    logic               master_en, slave_en, shadow_en;
    logic [CHAIN_W-1:0] chain_m, chain_s;

    scan_pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({cfg_load, cfg_sdi, shift_ph2, shift_ph1}),
        .pin_s (pins_s)
    );

    assign ph1_s  = pins_s[0];
    assign ph2_s  = pins_s[1];
    assign sdi_s  = pins_s[2];
    assign load_s = pins_s[3];

    scan_phase_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph1_s     (ph1_s),
        .ph2_s     (ph2_s),
        .load_s    (load_s),
        .state     (ph_state),
        .master_en (master_en),
        .slave_en  (slave_en),
        .shadow_en (shadow_en)
    );

    scan_shift_cells #(.CHAIN_W(CHAIN_W)) i_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .slave_en  (slave_en),
        .sdi_s     (sdi_s),
        .master_q  (chain_m),
        .slave_q   (chain_s),
        .sdo       (cfg_sdo)
    );

    scan_shadow_regs #(.COEF_W(COEF_W), .CTRL_W(CTRL_W), .TRIM_W(TRIM_W)) i_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (shadow_en),
        .chain_q   (chain_s),
        .gain_p    (gain_p),
        .gain_i    (gain_i),
        .gain_d    (gain_d),
        .ctrl_bits (ctrl_bits),
        .osc_trim  (osc_trim)
    );

endmodule

// File: rtl/scan_cfg_chain_chk.sv
module scan_cfg_chain_chk
    import scan_cfg_pkg::*;
#(
    parameter int CHAIN_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input ph_state_t          state,
    input logic               ph1_s,
    input logic               ph2_s,
    input logic               load_s,
    input logic [CHAIN_W-1:0] master_q,
    input logic [CHAIN_W-1:0] slave_q,
    input logic [CHAIN_W-1:0] shadow_word
);

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == PH_IDLE && load_s && !$past(load_s)) |=> $stable(shadow_word));

    // R6
    load_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE) |=> $stable(shadow_word));

    // R7
    clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_CLASH) |=> $stable(slave_q));

    // R7
    clash_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_CLASH && (ph1_s || ph2_s)) |=> (state == PH_CLASH));

    // R2
    slave_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LOAD_S) |=> (slave_q == $past(master_q)));

    // R9
    slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_LOAD_S) |=> $stable(slave_q));

endmodule

bind scan_cfg_chain scan_cfg_chain_chk #(.CHAIN_W(CHAIN_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (ph_state),
    .ph1_s       (ph1_s),
    .ph2_s       (ph2_s),
    .load_s      (load_s),
    .master_q    (chain_m),
    .slave_q     (chain_s),
    .shadow_word ({gain_p, gain_i, gain_d, ctrl_bits, osc_trim})
);

// File: tb/test_scan_cfg_chain.sv
`timescale 1ns/1ps
module test_scan_cfg_chain;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_ph1 = 1'b0;
    logic        shift_ph2 = 1'b0;
    logic        cfg_sdi = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_sdo;
    logic [15:0] gain_p, gain_i, gain_d;
    logic [7:0]  ctrl_bits, osc_trim;

    always #5 clk = ~clk;

    scan_cfg_chain i_scan_cfg_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_ph1 (shift_ph1),
        .shift_ph2 (shift_ph2),
        .cfg_sdi   (cfg_sdi),
        .cfg_load  (cfg_load),
        .cfg_sdo   (cfg_sdo),
        .gain_p    (gain_p),
        .gain_i    (gain_i),
        .gain_d    (gain_d),
        .ctrl_bits (ctrl_bits),
        .osc_trim  (osc_trim)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // Reference model: slave chain as a bit queue, index 0 = chain bit 63
    bit          q_s[$];
    bit          q_m[$];
    bit          ch_next[$];
    logic [63:0] exp_sh = '0;
    logic [63:0] sh_next = '0;
    int          cd_ch = 0;
    int          cd_sh = 0;

    function automatic logic [63:0] pack_q(input bit qq[$]);
        logic [63:0] w = '0;
        for (int i = 0; i < 64; i++) w[63-i] = qq[i];
        return w;
    endfunction

    task automatic model_clear();
        q_s.delete(); q_m.delete();
        for (int i = 0; i < 64; i++) begin q_s.push_back(1'b0); q_m.push_back(1'b0); end
        exp_sh = '0; cd_ch = 0; cd_sh = 0;
    endtask

    task automatic check_val(input string tag, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (cd_ch > 0) begin cd_ch--; if (cd_ch == 0) q_s = ch_next; end
        if (cd_sh > 0) begin cd_sh--; if (cd_sh == 0) exp_sh = sh_next; end
        @(negedge clk);
        check_val(cur_req, "cfg_sdo", {63'd0, cfg_sdo}, {63'd0, q_s[0]});
        check_val(cur_req, "shadow", {gain_p, gain_i, gain_d, ctrl_bits, osc_trim}, exp_sh);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic phase1(input bit b, input bit upd_mid);
        cfg_sdi = b;
        shift_ph1 = 1'b1;
        q_m = q_s; void'(q_m.pop_front()); q_m.push_back(b);
        if (upd_mid) begin
            ticks(3); cfg_load = 1'b1; ticks(3); cfg_load = 1'b0; ticks(4);
        end else ticks(6);
        shift_ph1 = 1'b0;
        ticks(6);
    endtask

    task automatic phase2();
        shift_ph2 = 1'b1;
        ch_next = q_m; cd_ch = 4;
        ticks(6);
        shift_ph2 = 1'b0;
        ticks(6);
    endtask

    task automatic load_word(input logic [63:0] w, input int upd_at,
                             output logic [63:0] rb);
        rb = '0;
        for (int k = 0; k < 64; k++) begin
            rb[63-k] = cfg_sdo;
            phase1(w[63-k], k == upd_at);
            phase2();
        end
    endtask

    task automatic pulse_load();
        cfg_load = 1'b1;
        sh_next = pack_q(q_s); cd_sh = 3;
        ticks(4);
        cfg_load = 1'b0;
        ticks(4);
    endtask

    task automatic check_fields(input string tag, input logic [63:0] w);
        check_val(tag, "gain_p",    {48'd0, gain_p},    {48'd0, w[63:48]});
        check_val(tag, "gain_i",    {48'd0, gain_i},    {48'd0, w[47:32]});
        check_val(tag, "gain_d",    {48'd0, gain_d},    {48'd0, w[31:16]});
        check_val(tag, "ctrl_bits", {56'd0, ctrl_bits}, {56'd0, w[15:8]});
        check_val(tag, "osc_trim",  {56'd0, osc_trim},  {56'd0, w[7:0]});
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] wa, wb, rb;
        wa = {16'hA5C3, 16'h1234, 16'hFEDC, 8'h81, 8'h3C};
        wb = {16'h0F71, 16'hC0DE, 16'h8001, 8'h5A, 8'hE7};
        model_clear();

        // R1: reset state
        cur_req = "R1";
        ticks(5);
        check_fields("R1", 64'd0);
        rst_n = 1'b1;
        ticks(3);

        // R2: shift word A, old contents are zero
        cur_req = "R2";
        load_word(wa, -1, rb);
        check_val("R2", "chain after 64 pairs", pack_q(q_s), wa);
        check_val("R5", "shadow before load", {gain_p, gain_i, gain_d, ctrl_bits, osc_trim}, 64'd0);

        // R8: load timing, checked each clock by the model
        cur_req = "R8";
        pulse_load();
        check_fields("R3", wa);

        // R4 / R6: shift word B, read A back, load pulse during a phase
        cur_req = "R4";
        load_word(wb, 10, rb);
        check_val("R4", "readback of word A", rb, wa);
        check_fields("R6", wa);
        cur_req = "R8";
        pulse_load();
        check_fields("R3", wb);

        // R9: lone second phase, then lone first phase
        cur_req = "R9";
        phase2();
        phase1(1'b1, 1'b0);
        ticks(4);
        pulse_load();
        check_fields("R9", wb);

        // R7: overlapping phases move no bit
        cur_req = "R7";
        cfg_sdi = 1'b0;
        shift_ph1 = 1'b1;
        q_m = q_s; void'(q_m.pop_front()); q_m.push_back(1'b0);
        ticks(6);
        shift_ph2 = 1'b1;
        ticks(6);
        shift_ph1 = 1'b0;
        ticks(6);
        shift_ph2 = 1'b0;
        ticks(6);
        pulse_load();
        check_fields("R7", wb);

        // R1: reset in mid-run
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        model_clear();
        check_fields("R1", 64'd0);
        check_val("R1", "cfg_sdo in reset", {63'd0, cfg_sdo}, 64'd0);
        ticks(3);
        rst_n = 1'b1;
        ticks(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule